// File: doc/BRIEF.md
# Serial-Loaded Output Driver Register

This block holds the 24-bit configuration of a driver with sixteen open-drain outputs. Eight of its physical channels can also act as diagnostics inputs. Configuration arrives one bit at a time on a serial input, and one strobe advances each bit. A separate latch strobe then copies the whole shift chain into a storage register in one step. The last stage of the shift chain is brought out, so several such registers can be chained in series and loaded with one long stream.

Each diagnostics channel n shares its pin with drain output n+1. A word may ask for both uses of one pin at the same time. In that case the block keeps the pin as an output, turns the diagnostics mode off, and records a sticky command error. Readback logic can sample this error and then clear it with a strobe.

The two serial clocks are handled as single-cycle enable strobes on the system clock. An output-enable input gates all drains. An active-low clear empties the shift chain and the error flag, and blanks the outputs until the next latch.

Top module: `sreg_driver_top`

## Requirements
- R1: After the synchronous reset `rst`, every output reads 0: `drain_on`, `diag_mode`, `cmd_err` and `sdo`.
- R2: Each cycle with `shift_stb` high moves the chain up one place and takes `sdi` into stage 0. `sdo` shows stage 23, so the first of 24 bits shifted in is the one that appears on `sdo`.
- R3: The storage register loads the chain only in a cycle with `latch_stb` high. Shifting alone leaves `drain_on` and `diag_mode` unchanged.
- R4: Storage bits [23:16] are the diagnostics requests for channels 7..0 and bits [15:0] are the drain requests for outputs 15..0. The outputs follow the stored value in the cycle after the latch.
- R5: Diagnostics request n is paired with drain request n+1. If both are 1, `diag_mode[n]` is 0 and `drain_on[n+1]` still follows its request. Drain 0 and drains 9..15 have no partner.
- R6: If a latch loads a word that has any conflicting pair, `cmd_err` is 1 from the cycle after that latch.
- R7: `cmd_err` stays set until `err_rd_clr` or a clear. If a conflicting latch and `err_rd_clr` occur in the same cycle, the flag is set.
- R8: While `oe` is 0, `drain_on` is all 0 one cycle later. `diag_mode` does not depend on `oe`.
- R9: While `clr_n` is 0, the shift chain, `cmd_err` and all outputs are zeroed, and the latch strobe is ignored. After `clr_n` returns to 1, the outputs stay 0 until the next latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Clear, active low, sampled on clk |
| sdi | input | 1 | Serial data in |
| shift_stb | input | 1 | Shift strobe, one cycle per bit |
| latch_stb | input | 1 | Copies the shift chain into storage |
| oe | input | 1 | Output enable for all drains |
| err_rd_clr | input | 1 | Clears the command-error flag after readback |
| sdo | output | 1 | Last shift stage, for daisy-chaining |
| drain_on | output | 16 | Drain outputs, 1 = sinking |
| diag_mode | output | 8 | Diagnostics mode active per channel |
| cmd_err | output | 1 | Sticky command-error flag |

## Verification
The hardest case to reach is a latch where a conflicting word and the read-and-clear strobe land in the same cycle. The bench shifts in a conflicting word in full and then raises both strobes on one edge. The other hard case is the conflict at the two ends of the pairing, diagnostics 0 against drain 1 and diagnostics 7 against drain 8. One word covers both ends, along with a legal diagnostics request and a drain that has no partner. Blanking after a clear is checked by holding the idle state for several cycles before the next latch.

// File: rtl/sreg_driver_pkg.sv
package sreg_driver_pkg;
  localparam int DEF_N_DRAIN = 16;
  localparam int DEF_N_DIAG  = 8;
endpackage

// File: rtl/sreg_chain.sv
module sreg_chain #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q,
  output logic         dout
);
  always_ff @(posedge clk) begin
    if (rst || !clr_n) q <= '0;
    else if (shift_en) q <= {q[W-2:0], din};
  end
  assign dout = q[W-1];
endmodule

// File: rtl/mode_resolve.sv
module mode_resolve #(
  parameter int N_DRAIN = 16,
  parameter int N_DIAG  = 8
) (
  input  logic [N_DRAIN-1:0] drain_req,
  input  logic [N_DIAG-1:0]  diag_req,
  output logic [N_DIAG-1:0]  diag_ok,
  output logic               conflict_any
);
  logic [N_DIAG-1:0] clash;
  for (genvar n = 0; n < N_DIAG; n++) begin : g_pair
    assign clash[n]   = diag_req[n] & drain_req[n+1];
    assign diag_ok[n] = diag_req[n] & ~drain_req[n+1];
  end
  assign conflict_any = |clash;
endmodule

// File: rtl/err_latch.sv
module err_latch (
  input  logic clk,
  input  logic rst,
  input  logic clr_n,
  input  logic set,
  input  logic rd_clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst || !clr_n) flag <= 1'b0;
    else if (set)      flag <= 1'b1;
    else if (rd_clr)   flag <= 1'b0;
  end
endmodule

// File: rtl/sreg_driver_top.sv
module sreg_driver_top
  import sreg_driver_pkg::*;
#(
  parameter int N_DRAIN = DEF_N_DRAIN,
  parameter int N_DIAG  = DEF_N_DIAG
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_n,
  input  logic               sdi,
  input  logic               shift_stb,
  input  logic               latch_stb,
  input  logic               oe,
  input  logic               err_rd_clr,
  output logic               sdo,
  output logic [N_DRAIN-1:0] drain_on,
  output logic [N_DIAG-1:0]  diag_mode,
  output logic               cmd_err
);
  localparam int W = N_DRAIN + N_DIAG;

  logic [W-1:0]      chain_q;
  logic [W-1:0]      store_q;
  logic              blank_q;
  logic [N_DIAG-1:0] diag_ok;
  logic [N_DIAG-1:0] diag_ok_in;
  logic              unused_conf;
  logic              conf_in;
  logic              do_latch;

  assign do_latch = latch_stb & clr_n;

  sreg_chain #(.W(W)) u_chain (
    .clk(clk), .rst(rst), .clr_n(clr_n), .shift_en(shift_stb),
    .din(sdi), .q(chain_q), .dout(sdo)
  );

  // resolution of the incoming word, used to set the error at latch time
  mode_resolve #(.N_DRAIN(N_DRAIN), .N_DIAG(N_DIAG)) u_res_in (
    .drain_req(chain_q[N_DRAIN-1:0]), .diag_req(chain_q[W-1:N_DRAIN]),
    .diag_ok(diag_ok_in), .conflict_any(conf_in)
  );

  // resolution of the stored word, drives the outputs
  mode_resolve #(.N_DRAIN(N_DRAIN), .N_DIAG(N_DIAG)) u_res_st (
    .drain_req(store_q[N_DRAIN-1:0]), .diag_req(store_q[W-1:N_DRAIN]),
    .diag_ok(diag_ok), .conflict_any(unused_conf)
  );

  err_latch u_err (
    .clk(clk), .rst(rst), .clr_n(clr_n), .set(do_latch & conf_in),
    .rd_clr(err_rd_clr), .flag(cmd_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      blank_q <= 1'b0;
    end else if (!clr_n) begin
      blank_q <= 1'b1;
    end else if (do_latch) begin
      store_q <= chain_q;
      blank_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !clr_n || blank_q) begin
      drain_on  <= '0;
      diag_mode <= '0;
    end else begin
      drain_on  <= oe ? store_q[N_DRAIN-1:0] : '0;
      diag_mode <= diag_ok;
    end
  end
endmodule

// File: rtl/sreg_driver_chk.sv
module sreg_driver_chk #(
  parameter int N_DRAIN = 16,
  parameter int N_DIAG  = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       clr_n,
  input logic                       sdi,
  input logic                       shift_stb,
  input logic                       latch_stb,
  input logic                       oe,
  input logic                       err_rd_clr,
  input logic                       sdo,
  input logic [N_DRAIN-1:0]         drain_on,
  input logic [N_DIAG-1:0]          diag_mode,
  input logic                       cmd_err,
  input logic [N_DRAIN+N_DIAG-1:0]  chain_q,
  input logic [N_DRAIN+N_DIAG-1:0]  store_q
);
  localparam int W = N_DRAIN + N_DIAG;

  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (shift_stb && clr_n) |=> (chain_q[0] == $past(sdi)));

  p_latch_r3: assert property (@(posedge clk) disable iff (rst)
    (latch_stb && clr_n) |=> (store_q == $past(chain_q)));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!latch_stb) |=> $stable(store_q));

  p_excl_r5: assert property (@(posedge clk) disable iff (rst)
    (diag_mode & drain_on[N_DIAG:1]) == '0);

  p_errset_r6: assert property (@(posedge clk) disable iff (rst)
    (latch_stb && clr_n && ((chain_q[W-1:N_DRAIN] & chain_q[N_DIAG:1]) != '0))
    |=> cmd_err);

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_err && clr_n && !err_rd_clr) |=> cmd_err);

  p_oe_r8: assert property (@(posedge clk) disable iff (rst)
    (!oe) |=> (drain_on == '0));

  p_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (!clr_n) |=> (drain_on == '0 && diag_mode == '0 && !cmd_err && !sdo));
endmodule

bind sreg_driver_top sreg_driver_chk #(.N_DRAIN(N_DRAIN), .N_DIAG(N_DIAG)) u_chk (
  .clk(clk), .rst(rst), .clr_n(clr_n), .sdi(sdi), .shift_stb(shift_stb),
  .latch_stb(latch_stb), .oe(oe), .err_rd_clr(err_rd_clr), .sdo(sdo),
  .drain_on(drain_on), .diag_mode(diag_mode), .cmd_err(cmd_err),
  .chain_q(chain_q), .store_q(store_q)
);

// File: tb/tb_sreg_driver_top.sv
module tb_sreg_driver_top;
  localparam int PER = 10;

  logic clk = 1'b0;
  logic rst = 1'b1, clr_n = 1'b1, sdi = 1'b0, shift_stb = 1'b0;
  logic latch_stb = 1'b0, oe = 1'b1, err_rd_clr = 1'b0;
  logic        sdo, cmd_err;
  logic [15:0] drain_on;
  logic [7:0]  diag_mode;

  sreg_driver_top dut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .sdi(sdi), .shift_stb(shift_stb),
    .latch_stb(latch_stb), .oe(oe), .err_rd_clr(err_rd_clr), .sdo(sdo),
    .drain_on(drain_on), .diag_mode(diag_mode), .cmd_err(cmd_err)
  );

  always #(PER/2) clk = ~clk;

  typedef struct {
    string       tag;
    logic [15:0] d;
    logic [7:0]  g;
    logic        e;
    logic        s;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // requirement model
  logic [23:0] sh_m = '0, st_m = '0;
  logic blank_m = 1'b0, err_m = 1'b0;

  task automatic expect_now(input string tag);
    item_t it;
    logic [7:0] dg;
    @(negedge clk);
    dg = st_m[23:16] & ~st_m[8:1];
    it.tag = tag;
    it.d   = (blank_m || !oe) ? 16'h0 : st_m[15:0];
    it.g   = blank_m ? 8'h0 : dg;
    it.e   = err_m;
    it.s   = sh_m[23];
    q.push_back(it);
  endtask

  task automatic shift_bit(input logic b);
    sdi = b; shift_stb = 1'b1;
    @(negedge clk);
    sh_m = {sh_m[22:0], b};
    shift_stb = 1'b0;
  endtask

  task automatic shift_word(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic latch(input logic rdclr);
    latch_stb = 1'b1; err_rd_clr = rdclr;
    @(negedge clk);
    latch_stb = 1'b0; err_rd_clr = 1'b0;
    st_m = sh_m; blank_m = 1'b0;
    if ((sh_m[23:16] & sh_m[8:1]) != 8'h0) err_m = 1'b1;
    else if (rdclr) err_m = 1'b0;
  endtask

  task automatic read_clear();
    err_rd_clr = 1'b1;
    @(negedge clk);
    err_rd_clr = 1'b0; err_m = 1'b0;
  endtask

  task automatic do_clear();
    clr_n = 1'b0; latch_stb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    clr_n = 1'b1; latch_stb = 1'b0;
    sh_m = '0; err_m = 1'b0; blank_m = 1'b1;
  endtask

  // monitor: compares queued expectations shortly after a falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (drain_on !== it.d || diag_mode !== it.g || cmd_err !== it.e || sdo !== it.s) begin
          errors++;
          $display("FAIL %s: got drain=%h diag=%h err=%b sdo=%b exp drain=%h diag=%h err=%b sdo=%b",
                   it.tag, drain_on, diag_mode, cmd_err, sdo, it.d, it.g, it.e, it.s);
        end
      end
    end
  end

  initial begin
    #(PER * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_now("R1 reset state");

    shift_word(24'h00_A5C3);
    expect_now("R3 shift without latch keeps outputs, R2 sdo");
    latch(1'b0);
    expect_now("R4 field mapping after latch");

    shift_word(24'h89_0103);
    latch(1'b0);
    expect_now("R5 R6 conflict at diag0/drain1 and diag7/drain8");

    shift_word(24'h3C_0001);
    latch(1'b0);
    expect_now("R7 flag sticky over legal word");

    read_clear();
    expect_now("R7 read-and-clear");

    shift_word(24'h89_0103);
    latch(1'b1);
    expect_now("R7 set wins over read-clear");

    oe = 1'b0;
    expect_now("R8 oe low blocks drains");
    oe = 1'b1;
    expect_now("R8 oe high restores drains");

    shift_word(24'hC0_0000);
    expect_now("R2 daisy-chain first bit on sdo");
    shift_bit(1'b0);
    expect_now("R2 daisy-chain second bit on sdo");
    shift_bit(1'b0);
    expect_now("R2 daisy-chain third bit on sdo");

    shift_word(24'hFF_FFFF);
    do_clear();
    expect_now("R9 clear zeroes everything");
    repeat (3) @(negedge clk);
    expect_now("R9 outputs blank until next latch");

    shift_word(24'h42_0021);
    latch(1'b0);
    expect_now("R9 latch after clear restores outputs");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule